// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz time-base clock enable into a periodic interrupt event. A 4-bit rate code and a 3-bit divider code pick the event period. It also keeps an interrupt status byte that records three events: the periodic tick, an alarm match and the end of a time update. Each event has its own enable. The block combines every enabled, pending event into one request bit and drives that bit onto an interrupt output. When the square-wave enable is set, a square wave at the selected rate is also driven out.

The status byte is cleared by a read-clear strobe. The alarm and update-ended events arrive from neighbouring logic as single-cycle pulses. The oscillator and the time counting are outside this block. Two divider codes hold the divider chain at zero. While the chain is held, no periodic events occur, and when the hold is released the chain counts again from a known phase.

Top module: `periodic_irq_gen`

## Requirements
- R1: A rate code of 0 produces no periodic event, whatever the divider code.
- R2: With the chain running and a rate code c from 3 to 15, a periodic event occurs every 2^(c-1) time-base ticks. The first event comes on tick 2^(c-1) after the hold is released, so code 3 gives a period of 4 ticks and code 15 gives 16384 ticks.
- R3: Rate codes 1 and 2 depend on the divider code. With divider code 2 (the slow base), they give periods of 128 and 256 ticks. With any other running divider code, they give periods of 1 and 2 ticks.
- R4: Divider codes 6 and 7 clear the divider chain and hold it at zero. While held, there are no periodic events and the square-wave output is low.
- R5: The status byte places the update-ended flag at bit 4, the alarm flag at bit 5, the periodic flag at bit 6 and the request flag at bit 7. Bits 3 to 0 read as zero.
- R6: Each event flag sets on the clock edge after its event, whether or not its interrupt is enabled.
- R7: The request flag and the interrupt output are high exactly when at least one set flag has its enable high. The update enable pairs with bit 4, the alarm enable with bit 5 and the periodic enable with bit 6.
- R8: A read-clear strobe clears all flags on the next edge. An event in the same cycle as the strobe leaves its own flag set.
- R9: When the square-wave enable is set and the period is 2^k ticks with k of at least 1, the square-wave output is low for the first 2^(k-1) ticks of each period and high for the rest. When the square-wave enable is clear, or k is 0, the output is low.
- R10: After reset, the status byte is zero, the interrupt output is low and the divider chain starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baseTick | input | 1 | One-cycle pulse per 32768 Hz time-base period |
| rateSel | input | 4 | Periodic rate code |
| divSel | input | 3 | Divider code: 2 is the slow base, 6 and 7 hold the chain |
| updIntEn | input | 1 | Update-ended interrupt enable |
| almIntEn | input | 1 | Alarm interrupt enable |
| perIntEn | input | 1 | Periodic interrupt enable |
| sqwEn | input | 1 | Square-wave output enable |
| updateEvt | input | 1 | Update-ended event pulse |
| alarmEvt | input | 1 | Alarm match event pulse |
| flagClear | input | 1 | Read-clear strobe for the status byte |
| flagReg | output | 8 | Status byte: request, periodic, alarm and update-ended flags |
| irqOut | output | 1 | Interrupt request, active high |
| sqwOut | output | 1 | Square-wave output |

## Verification
The assertions take the time-base enable and the event inputs to be single-cycle pulses that are synchronous to the clock. They also take the rate and divider codes to be stable from one tick to the next. The stimulus changes the codes only while the chain is held by divider code 7 and then releases the hold. Every period is therefore measured from a known zero phase, and every time-base pulse is separated from the next by an idle cycle.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int RATE_W = 4;
  localparam int DIV_W = 3;
  localparam int CNT_W = (1 << RATE_W) - 2;

  typedef struct packed {
    logic hold;
    logic perOn;
    logic [RATE_W-1:0] tapK;
  } divCtl_t;
endpackage

// File: rtl/rate_ctrl.sv
module rate_ctrl
  import prg_pkg::*;
#(
  parameter int SLOW_BASE = 2,
  parameter int HOLD_MIN = 6,
  parameter int FAST_LAST = 2,
  parameter int SLOW_SHIFT = 6
) (
  input  logic [RATE_W-1:0] rateSel,
  input  logic [DIV_W-1:0]  divSel,
  output divCtl_t           ctl
);
  always_comb begin
    ctl.hold  = (int'(divSel) >= HOLD_MIN);
    ctl.perOn = (rateSel != '0);
    if (rateSel == '0)
      ctl.tapK = '0;
    else if ((int'(rateSel) <= FAST_LAST) && (int'(divSel) == SLOW_BASE))
      ctl.tapK = rateSel + RATE_W'(SLOW_SHIFT);
    else
      ctl.tapK = rateSel - RATE_W'(1);
  end
endmodule

// File: rtl/div_chain.sv
module div_chain
  import prg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    baseTick,
  input  logic    sqwEn,
  input  divCtl_t ctl,
  output logic    perEvt,
  output logic    sqwOut
);
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W:0]   maskWide;
  logic [CNT_W-1:0] lowMask;
  logic [CNT_W-1:0] halfMask;

  always_comb begin
    maskWide = ({{CNT_W{1'b0}}, 1'b1} << ctl.tapK) - 1'b1;
    lowMask  = maskWide[CNT_W-1:0];
    halfMask = lowMask ^ (lowMask >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         divCnt <= '0;
    else if (ctl.hold) divCnt <= '0;
    else if (baseTick) divCnt <= divCnt + 1'b1;
  end

  assign perEvt = baseTick & ~ctl.hold & ctl.perOn & ((divCnt & lowMask) == lowMask);
  assign sqwOut = sqwEn & ~ctl.hold & (|(divCnt & halfMask));
endmodule

// File: rtl/irq_flags.sv
module irq_flags (
  input  logic       clk,
  input  logic       rstN,
  input  logic       updEvt,
  input  logic       almEvt,
  input  logic       perEvt,
  input  logic       clear,
  input  logic       updEn,
  input  logic       almEn,
  input  logic       perEn,
  output logic [7:0] flagReg,
  output logic       irqOut
);
  logic updFlag, almFlag, perFlag, reqBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updFlag <= 1'b0;
      almFlag <= 1'b0;
      perFlag <= 1'b0;
    end else begin
      updFlag <= updEvt | (updFlag & ~clear);
      almFlag <= almEvt | (almFlag & ~clear);
      perFlag <= perEvt | (perFlag & ~clear);
    end
  end

  assign reqBit  = (updFlag & updEn) | (almFlag & almEn) | (perFlag & perEn);
  assign flagReg = {reqBit, perFlag, almFlag, updFlag, 4'b0000};
  assign irqOut  = reqBit;

  assert_evt_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (updEvt | almEvt | perEvt) |=> ((flagReg[4] | ~$past(updEvt)) & (flagReg[5] | ~$past(almEvt)) & (flagReg[6] | ~$past(perEvt))));
  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clear & ~updEvt & ~almEvt & ~perEvt) |=> (flagReg[6:4] == 3'b000));
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import prg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [DIV_W-1:0]  divSel,
  input  logic              updIntEn,
  input  logic              almIntEn,
  input  logic              perIntEn,
  input  logic              sqwEn,
  input  logic              updateEvt,
  input  logic              alarmEvt,
  input  logic              flagClear,
  output logic [7:0]        flagReg,
  output logic              irqOut,
  output logic              sqwOut
);
  divCtl_t divCtl;
  logic    perEvt;

  rate_ctrl uCtrl (.rateSel(rateSel), .divSel(divSel), .ctl(divCtl));

  div_chain uChain (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .sqwEn(sqwEn),
    .ctl(divCtl), .perEvt(perEvt), .sqwOut(sqwOut)
  );

  irq_flags uFlags (
    .clk(clk), .rstN(rstN), .updEvt(updateEvt), .almEvt(alarmEvt),
    .perEvt(perEvt), .clear(flagClear), .updEn(updIntEn), .almEn(almIntEn),
    .perEn(perIntEn), .flagReg(flagReg), .irqOut(irqOut)
  );

  assert_rate_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel == '0) |-> !perEvt);
  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (divSel >= 3'd6) |-> (!perEvt && !sqwOut));
endmodule

// File: tb/tb_periodic_irq_gen.sv
module tb_periodic_irq_gen;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baseTick = 1'b0;
  logic [3:0] rateSel = 4'd0;
  logic [2:0] divSel = 3'd7;
  logic updIntEn = 1'b0, almIntEn = 1'b0, perIntEn = 1'b0, sqwEn = 1'b0;
  logic updateEvt = 1'b0, alarmEvt = 1'b0, flagClear = 1'b0;
  logic [7:0] flagReg;
  logic irqOut, sqwOut;
  int checkCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  periodic_irq_gen dut (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .rateSel(rateSel),
    .divSel(divSel), .updIntEn(updIntEn), .almIntEn(almIntEn),
    .perIntEn(perIntEn), .sqwEn(sqwEn), .updateEvt(updateEvt),
    .alarmEvt(alarmEvt), .flagClear(flagClear), .flagReg(flagReg),
    .irqOut(irqOut), .sqwOut(sqwOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) baseTick = 1'b1;
      @(negedge clk) baseTick = 1'b0;
    end
  endtask

  task automatic clearFlags();
    @(negedge clk) flagClear = 1'b1;
    @(negedge clk) flagClear = 1'b0;
  endtask

  task automatic restart(input logic [3:0] rate, input logic [2:0] div);
    @(negedge clk) divSel = 3'd7; rateSel = rate;
    clearFlags();
    @(negedge clk) divSel = div;
  endtask

  task automatic testPeriod(input logic [3:0] rate, input logic [2:0] div, input int k, input string req);
    restart(rate, div);
    if (k > 0) begin
      ticks((1 << k) - 1);
      check(flagReg[6] == 1'b0, req, flagReg[6], 0);
    end
    ticks(1);
    check(flagReg[6] == 1'b1, req, flagReg[6], 1);
  endtask

  task automatic testReset();
    check(flagReg == 8'h00, "R10", flagReg, 8'h00);
    check(irqOut == 1'b0, "R10", irqOut, 0);
  endtask

  task automatic testRateOff();
    restart(4'd0, 3'd0);
    ticks(64);
    check(flagReg[6] == 1'b0, "R1", flagReg[6], 0);
  endtask

  task automatic testHold();
    restart(4'd3, 3'd6);
    sqwEn = 1'b1;
    ticks(40);
    check(flagReg[6] == 1'b0, "R4", flagReg[6], 0);
    check(sqwOut == 1'b0, "R4", sqwOut, 0);
    sqwEn = 1'b0;
  endtask

  task automatic testSquare();
    restart(4'd4, 3'd2);
    sqwEn = 1'b1;
    ticks(3);
    check(sqwOut == 1'b0, "R9", sqwOut, 0);
    ticks(1);
    check(sqwOut == 1'b1, "R9", sqwOut, 1);
    ticks(3);
    check(sqwOut == 1'b1, "R9", sqwOut, 1);
    ticks(1);
    check(sqwOut == 1'b0, "R9", sqwOut, 0);
    ticks(4);
    @(negedge clk) sqwEn = 1'b0;
    #1 check(sqwOut == 1'b0, "R9", sqwOut, 0);
    restart(4'd1, 3'd0);
    sqwEn = 1'b1;
    ticks(1);
    check(sqwOut == 1'b0, "R9", sqwOut, 0);
    sqwEn = 1'b0;
  endtask

  task automatic testFlags();
    restart(4'd0, 3'd2);
    @(negedge clk) updateEvt = 1'b1;
    @(negedge clk) updateEvt = 1'b0;
    check(flagReg == 8'h10, "R6 R5", flagReg, 8'h10);
    check(irqOut == 1'b0, "R7", irqOut, 0);
    @(negedge clk) alarmEvt = 1'b1;
    @(negedge clk) alarmEvt = 1'b0;
    check(flagReg == 8'h30, "R5", flagReg, 8'h30);
    almIntEn = 1'b1;
    #1 check(flagReg == 8'hB0 && irqOut == 1'b1, "R7", flagReg, 8'hB0);
    almIntEn = 1'b0;
    perIntEn = 1'b1;
    #1 check(irqOut == 1'b0, "R7", irqOut, 0);
    @(negedge clk) flagClear = 1'b1; alarmEvt = 1'b1;
    @(negedge clk) flagClear = 1'b0; alarmEvt = 1'b0;
    check(flagReg == 8'h20, "R8", flagReg, 8'h20);
    clearFlags();
    check(flagReg == 8'h00, "R8", flagReg, 8'h00);
    restart(4'd3, 3'd2);
    ticks(4);
    check(flagReg == 8'hC0 && irqOut == 1'b1, "R7", flagReg, 8'hC0);
    perIntEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    checkCount++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRateOff();
    testPeriod(4'd3, 3'd2, 2, "R2");
    testPeriod(4'd7, 3'd0, 6, "R2");
    testPeriod(4'd15, 3'd1, 14, "R2");
    testPeriod(4'd1, 3'd2, 7, "R3");
    testPeriod(4'd2, 3'd2, 8, "R3");
    testPeriod(4'd1, 3'd0, 0, "R3");
    testPeriod(4'd2, 3'd1, 1, "R3");
    testHold();
    testSquare();
    testFlags();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule